// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks control flow for one warp of 32 threads that share a single program counter. It gives the issue stage the current PC and active-thread mask. Each cycle the issue stage may report that the warp moved to the next instruction, or that it ran a branch. A branch event carries a per-thread taken predicate, a target address, a fall-through address and the address where both paths meet again.

A branch is uniform when, after the predicate is masked by the active mask, every active thread goes the same way. A uniform branch only moves the PC. A divergent branch saves two contexts on a stack. The first is the meeting point with the mask that was in force before the branch. The second is the fall-through path with the not-taken threads. The warp then runs the taken threads alone. When the next PC would equal the meeting address of the running path, the top saved context is popped and resumed. The not-taken threads run next, and then the full original mask is back at the meeting address. A divergence that finds fewer than two free entries sets a sticky overflow flag and is dropped.

Top module: `simt_recon_stack`

## Requirements
- R1: After reset, pc_o is 0, mask_o is all ones, depth_o is 0 and overflow_o is 0.
- R2: With adv_i high and no branch, pc_o rises by 4 on the next cycle and mask_o is unchanged.
- R3: A branch is uniform when (br_taken_i & mask_o) equals mask_o or equals 0. Such a branch sets pc_o to br_target_i or br_fall_i and pushes nothing. Predicate bits of inactive threads have no effect.
- R4: A divergent branch sets pc_o to br_target_i on the next cycle, mask_o to mask_o & br_taken_i, and depth_o to depth_o + 2.
- R5: On the taken path, when the next PC would equal the path's meeting address, the warp resumes at the fall-through address. Its mask is the original mask & ~predicate, and depth_o drops by 1.
- R6: When the not-taken path reaches the meeting address, pc_o becomes that address and mask_o becomes the mask from before the branch. depth_o drops by 1.
- R7: If the running path's pc_o already equals its meeting address, it is popped on the next cycle. adv_i and branches in that cycle are ignored.
- R8: Nested divergences unwind innermost first. Each level restores its own saved mask at its own meeting address.
- R9: The stack holds 8 entries. A divergent branch with fewer than 2 free entries sets overflow_o. pc_o, mask_o and depth_o stay unchanged, and overflow_o stays set until reset.
- R10: When br_valid_i and adv_i are both high, the branch decides the next PC.
- R11: With neither adv_i nor br_valid_i high, pc_o, mask_o and depth_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Warp issued a non-branch instruction |
| br_valid_i | input | 1 | Warp issued a branch this cycle |
| br_taken_i | input | 32 | Per-thread taken predicate |
| br_target_i | input | 32 | Taken-path address |
| br_fall_i | input | 32 | Not-taken-path address |
| br_recon_i | input | 32 | Meeting address of both paths |
| pc_o | output | 32 | Current warp PC |
| mask_o | output | 32 | Current active-thread mask |
| depth_o | output | 4 | Saved entries on the stack |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
Every result here is registered once. A branch or advance applied in one cycle shows on pc_o, mask_o, depth_o and overflow_o after the next rising edge. The only exception is the empty-path pop, which takes one extra cycle of its own. The bench drives each event on a falling edge and holds it across one rising edge. It reads the outputs on the following falling edge, which is exactly one register stage later. For the empty-path case, the bench takes a second sample one cycle after that.

// File: rtl/simt_pkg.sv
package simt_pkg;
  localparam int WARP = 32;
  localparam int PC_W = 32;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [WARP-1:0] mask;
    logic [PC_W-1:0] rpc;
    logic            has_rpc;
  } simt_ctx_t;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
  import simt_pkg::*;
(
  input  logic [WARP-1:0] act_i,
  input  logic [WARP-1:0] pred_i,
  output logic [WARP-1:0] tk_mask_o,
  output logic [WARP-1:0] nt_mask_o,
  output logic            uniform_o,
  output logic            all_tk_o
);
  always_comb begin
    tk_mask_o = act_i & pred_i;
    nt_mask_o = act_i & ~pred_i;
    all_tk_o  = (nt_mask_o == '0);
    uniform_o = all_tk_o || (tk_mask_o == '0);
  end
endmodule

// File: rtl/simt_ctx_stack.sv
module simt_ctx_stack
  import simt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push2_i,
  input  logic                         pop_i,
  input  simt_ctx_t                    lo_i,
  input  simt_ctx_t                    hi_i,
  output simt_ctx_t                    top_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic                         room2_o
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] depth_q;
  simt_ctx_t        slot_rd [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    simt_ctx_t slot_q;
    always_ff @(posedge clk_i) begin
      if (push2_i) begin
        if (CNT_W'(i) == depth_q) slot_q <= lo_i;
        else if (CNT_W'(i) == depth_q + CNT_W'(1)) slot_q <= hi_i;
      end
    end
    assign slot_rd[i] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else if (push2_i) depth_q <= depth_q + CNT_W'(2);
    else if (pop_i) depth_q <= depth_q - CNT_W'(1);
  end

  always_comb begin
    top_o   = (depth_q == '0) ? '0 : slot_rd[IDX_W'(depth_q - CNT_W'(1))];
    room2_o = (int'(depth_q) <= DEPTH - 2);
    depth_o = depth_q;
  end

  // R5
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> depth_q != '0);
  // R9
  push_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push2_i |-> int'(depth_q) <= DEPTH - 2);
  // R9
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_q) <= DEPTH);
  // R4
  excl_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push2_i && pop_i));
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int STEP_BYTES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  input  logic                       br_valid_i,
  input  logic [WARP-1:0]            br_taken_i,
  input  logic [PC_W-1:0]            br_target_i,
  input  logic [PC_W-1:0]            br_fall_i,
  input  logic [PC_W-1:0]            br_recon_i,
  output logic [PC_W-1:0]            pc_o,
  output logic [WARP-1:0]            mask_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       overflow_o
);
  simt_ctx_t ctx_q, ctx_d, top_w, lo_w, hi_w;
  logic      ovf_q, ovf_d;
  logic      push2, pop, room2;
  logic      uniform, all_tk, empty_path, move;
  logic [WARP-1:0] tk_m, nt_m;
  logic [PC_W-1:0] npc;

  simt_branch_split u_split (
    .act_i     (ctx_q.mask),
    .pred_i    (br_taken_i),
    .tk_mask_o (tk_m),
    .nt_mask_o (nt_m),
    .uniform_o (uniform),
    .all_tk_o  (all_tk)
  );

  simt_ctx_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push2_i (push2),
    .pop_i   (pop),
    .lo_i    (lo_w),
    .hi_i    (hi_w),
    .top_o   (top_w),
    .depth_o (depth_o),
    .room2_o (room2)
  );

  assign empty_path = ctx_q.has_rpc && (ctx_q.pc == ctx_q.rpc);

  always_comb begin
    ctx_d = ctx_q;
    ovf_d = ovf_q;
    push2 = 1'b0;
    pop   = 1'b0;
    move  = 1'b0;
    npc   = ctx_q.pc;
    lo_w  = '{pc: br_recon_i, mask: ctx_q.mask, rpc: ctx_q.rpc, has_rpc: ctx_q.has_rpc};
    hi_w  = '{pc: br_fall_i, mask: nt_m, rpc: br_recon_i, has_rpc: 1'b1};
    if (empty_path) begin
      pop   = 1'b1;
      ctx_d = top_w;
    end else if (br_valid_i) begin
      if (uniform) begin
        npc  = all_tk ? br_target_i : br_fall_i;
        move = 1'b1;
      end else if (room2) begin
        push2 = 1'b1;
        ctx_d = '{pc: br_target_i, mask: tk_m, rpc: br_recon_i, has_rpc: 1'b1};
      end else begin
        ovf_d = 1'b1;
      end
    end else if (adv_i) begin
      npc  = ctx_q.pc + PC_W'(STEP_BYTES);
      move = 1'b1;
    end
    if (move) begin
      if (ctx_q.has_rpc && npc == ctx_q.rpc) begin
        pop   = 1'b1;
        ctx_d = top_w;
      end else begin
        ctx_d.pc = npc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= '{pc: '0, mask: '1, rpc: '0, has_rpc: 1'b0};
      ovf_q <= 1'b0;
    end else begin
      ctx_q <= ctx_d;
      ovf_q <= ovf_d;
    end
  end

  assign pc_o       = ctx_q.pc;
  assign mask_o     = ctx_q.mask;
  assign overflow_o = ovf_q;

  // R4
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o != '0);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R4
  div_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !uniform && !empty_path && room2)
      |=> (depth_o == $past(depth_o) + 2) && ((mask_o & ~$past(mask_o)) == '0));
  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !uniform && !empty_path && !room2)
      |=> $stable(pc_o) && $stable(mask_o) && $stable(depth_o) && overflow_o);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_valid_i && !adv_i && !empty_path) |=> $stable(pc_o) && $stable(mask_o));
endmodule

// File: tb/simt_recon_stack_tb.sv
module simt_recon_stack_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0, brv = 1'b0;
  logic [31:0] pred = '0, tgt = '0, fall = '0, rec = '0;
  logic [31:0] pc, mask;
  logic [3:0]  depth;
  logic        ovf;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_recon_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .br_valid_i(brv),
    .br_taken_i(pred), .br_target_i(tgt), .br_fall_i(fall), .br_recon_i(rec),
    .pc_o(pc), .mask_o(mask), .depth_o(depth), .overflow_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] epc, input logic [31:0] emask,
                     input int edep);
    checks++;
    if (pc !== epc || mask !== emask || int'(depth) !== edep) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h depth=%0d expected pc=%h mask=%h depth=%0d",
               tag, pc, mask, depth, epc, emask, edep);
    end
  endtask

  task automatic chk_ovf(input string tag, input logic e);
    checks++;
    if (ovf !== e) begin
      errors++;
      $display("FAIL %s: overflow=%b expected %b", tag, ovf, e);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input logic [31:0] p,
                     input logic [31:0] t, input logic [31:0] f, input logic [31:0] r);
    adv = a; brv = b; pred = p; tgt = t; fall = f; rec = r;
    @(negedge clk);
    adv = 0; brv = 0; pred = '0; tgt = '0; fall = '0; rec = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 32'h0, ALL, 0);
    chk_ovf("R1 reset ovf", 1'b0);
  endtask

  task automatic t_linear;
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 adv", 32'h4, ALL, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 adv2", 32'h8, ALL, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R11 idle", 32'h8, ALL, 0);
    cyc(1, 1, ALL, 32'h100, 32'hC, 32'h900);
    chk("R10 branch beats adv", 32'h100, ALL, 0);
    cyc(0, 1, 32'h0, 32'h180, 32'h104, 32'h900);
    chk("R3 uniform not taken", 32'h104, ALL, 0);
  endtask

  task automatic t_diverge;
    cyc(0, 1, 32'h0000_FFFF, 32'h200, 32'h108, 32'h300);
    chk("R4 diverge", 32'h200, 32'h0000_FFFF, 2);
    cyc(0, 1, 32'hFFFF_0000, 32'h280, 32'h204, 32'h900);
    chk("R3 inactive bits ignored", 32'h204, 32'h0000_FFFF, 2);
    cyc(0, 1, ALL, 32'h300, 32'h208, 32'h900);
    chk("R5 taken path done", 32'h108, 32'hFFFF_0000, 1);
    cyc(0, 1, ALL, 32'h2FC, 32'h10C, 32'h900);
    chk("R3 uniform on nt path", 32'h2FC, 32'hFFFF_0000, 1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R6 reconverge", 32'h300, ALL, 0);
  endtask

  task automatic t_empty;
    cyc(0, 1, 32'h1, 32'h400, 32'h304, 32'h400);
    chk("R7 empty taken path", 32'h400, 32'h1, 2);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R7 auto pop, adv ignored", 32'h304, 32'hFFFF_FFFE, 1);
    cyc(0, 1, ALL, 32'h400, 32'h308, 32'h900);
    chk("R6 reconverge after empty", 32'h400, ALL, 0);
  endtask

  task automatic t_nest;
    cyc(0, 1, 32'h0000_FFFF, 32'h500, 32'h404, 32'h600);
    chk("R8 level1", 32'h500, 32'h0000_FFFF, 2);
    cyc(0, 1, 32'h0000_00FF, 32'h510, 32'h504, 32'h580);
    chk("R8 level2", 32'h510, 32'h0000_00FF, 4);
    cyc(0, 1, 32'h0000_000F, 32'h520, 32'h514, 32'h540);
    chk("R8 level3", 32'h520, 32'h0000_000F, 6);
    cyc(0, 1, 32'h0000_0003, 32'h530, 32'h524, 32'h538);
    chk("R9 full stack", 32'h530, 32'h3, 8);
    chk_ovf("R9 no overflow yet", 1'b0);
    cyc(0, 1, 32'h1, 32'h700, 32'h534, 32'h710);
    chk("R9 overflow holds state", 32'h530, 32'h3, 8);
    chk_ovf("R9 overflow set", 1'b1);
    cyc(0, 1, ALL, 32'h538, 32'h534, 32'h900);
    chk("R8 unwind l4 taken", 32'h524, 32'hC, 7);
    cyc(0, 1, ALL, 32'h538, 32'h528, 32'h900);
    chk("R8 unwind l4 join", 32'h538, 32'hF, 6);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R8 unwind l3 taken", 32'h514, 32'hF0, 5);
    cyc(0, 1, ALL, 32'h540, 32'h518, 32'h900);
    chk("R8 unwind l3 join", 32'h540, 32'hFF, 4);
    cyc(0, 1, ALL, 32'h580, 32'h544, 32'h900);
    chk("R8 unwind l2 taken", 32'h504, 32'hFF00, 3);
    cyc(0, 1, ALL, 32'h580, 32'h508, 32'h900);
    chk("R8 unwind l2 join", 32'h580, 32'hFFFF, 2);
    cyc(0, 1, ALL, 32'h600, 32'h584, 32'h900);
    chk("R8 unwind l1 taken", 32'h404, 32'hFFFF_0000, 1);
    cyc(0, 1, ALL, 32'h600, 32'h408, 32'h900);
    chk("R8 unwind l1 join", 32'h600, ALL, 0);
    chk_ovf("R9 overflow sticky", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_diverge();
    t_empty();
    t_nest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule